// File: doc/BRIEF.md
# Power-Fail Write-Protect and Backup Switch Sequencer

This block supervises a battery-backed static RAM. It watches three supply comparator flags: supply good enough to run, supply still above the protect level, and supply above the switchover level. From them it decides whether memory accesses may reach the array, whether the data pins may be driven, and which source powers the RAM: the external supply or a backup cell. It filters every flag through a synchronizer and a stability counter first, so a short glitch cannot start a protect or switchover event.

Protection uses hysteresis. Once the filtered protect flag drops, the array is cut off: chip enable and write enable to the array go inactive, and the data drivers turn off. Any access in flight is aborted at that same clock edge. Protection lifts only when the filtered run flag comes back high. A shipping seal keeps the backup cell disconnected until the first valid power-up. After that the seal stays armed through ordinary resets and is cleared only by a dedicated factory input.

Top module: `nvs_supervisor`

## Requirements
- R1: While `rst` is high and on the cycle after it, `arr_ce_n` and `arr_we_n` are 1, and `dq_drive`, `pwr_sel_ext` and `pwr_sel_bat` are 0.
- R2: Each supply flag passes two synchronizer flops. A change is accepted only after the synchronized value has differed from the accepted value for STABLE_CYCLES consecutive cycles (default 4). A pulse shorter than that has no effect at any output.
- R3: Protection is released only when the filtered run flag (`sup_run_ok`) is 1 and the filtered protect flag is 1. A return of the protect flag alone leaves the block protected.
- R4: A filtered protect flag (`sup_prot_ok`) of 0 puts the block into protection on the next edge. Between the two thresholds (run flag 0, protect flag 1) the previous state is held.
- R5: While protected, `arr_ce_n`=1, `arr_we_n`=1 and `dq_drive`=0, whatever `ce_n`, `oe_n` and `we_n` do.
- R6: At the edge where protection asserts, an ongoing write is aborted: `arr_we_n` and `arr_ce_n` go to 1 at that same edge.
- R7: While unprotected, the outputs follow the inputs one cycle later. `arr_ce_n`=`ce_n`, `arr_we_n`=`ce_n|we_n`, and `dq_drive`=1 only for a read (`ce_n`=0, `oe_n`=0, `we_n`=1). A low `we_n` turns the drivers off.
- R8: `pwr_sel_ext` equals the filtered switchover flag delayed one cycle. `pwr_sel_bat` is 1 only when the seal is armed and the filtered switchover flag is 0. The two are never 1 together.
- R9: `seal_armed` clears on `seal_clear`. It sets the first time the filtered run flag is 1 and then stays set, through `rst`, until `seal_clear`. While it is 0, `pwr_sel_bat` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (does not touch the seal) |
| seal_clear | input | 1 | Factory clear of the shipping seal |
| sup_run_ok | input | 1 | Comparator: supply above operating threshold (asynchronous) |
| sup_prot_ok | input | 1 | Comparator: supply above protect threshold (asynchronous) |
| sup_sw_ok | input | 1 | Comparator: supply above switchover level (asynchronous) |
| ce_n | input | 1 | Host chip enable, active low |
| oe_n | input | 1 | Host output enable, active low |
| we_n | input | 1 | Host write enable, active low |
| arr_ce_n | output | 1 | Gated chip enable to the array |
| arr_we_n | output | 1 | Gated write enable to the array |
| dq_drive | output | 1 | Enable for the data output drivers |
| pwr_sel_ext | output | 1 | RAM powered from external supply |
| pwr_sel_bat | output | 1 | RAM powered from backup cell |
| seal_armed | output | 1 | Shipping seal removed, backup enabled |

## Verification
The assertions assume that the comparator flags are ordered, so that a supply good enough to run is also above the protect and switchover levels. They also assume that the host controls are synchronous to `clk`. The stimulus follows this. It raises the flags in the order switchover, protect, run and lowers them in the reverse order. The one exception is deliberate and short: glitches on a single flag that the filter must absorb. All host control changes fall on the falling clock edge, half a period away from the sampling edge.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  localparam int NUM_FLAGS = 3;
  localparam int FLAG_RUN  = 0;
  localparam int FLAG_PROT = 1;
  localparam int FLAG_SW   = 2;

  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
  } mem_ctl_t;

  typedef enum logic {
    PS_GUARD = 1'b0,
    PS_OPEN  = 1'b1
  } prot_state_t;
endpackage

// File: rtl/nvs_flag_filter.sv
module nvs_flag_filter #(
  parameter int SYNC_STAGES   = 2,
  parameter int STABLE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic filt
);
  localparam int CNT_W = (STABLE_CYCLES < 2) ? 1 : $clog2(STABLE_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STABLE_CYCLES - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CNT_W-1:0]       cnt_q;
  logic                   synced;

  assign synced = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      cnt_q  <= '0;
      filt   <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
      if (synced != filt) begin
        if (cnt_q == CNT_LAST) begin
          filt  <= synced;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end
endmodule

// File: rtl/nvs_protect_fsm.sv
module nvs_protect_fsm
  import nvs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic run_ok,
  input  logic prot_ok,
  output logic prot_next,
  output logic prot_q
);
  prot_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (!prot_ok)
      st_d = PS_GUARD;
    else if (run_ok)
      st_d = PS_OPEN;
  end

  assign prot_next = (st_d == PS_GUARD);
  assign prot_q    = (st_q == PS_GUARD);

  always_ff @(posedge clk) begin
    if (rst) st_q <= PS_GUARD;
    else     st_q <= st_d;
  end
endmodule

// File: rtl/nvs_access_gate.sv
module nvs_access_gate
  import nvs_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     prot_next,
  input  mem_ctl_t host,
  output logic     arr_ce_n,
  output logic     arr_we_n,
  output logic     dq_drive
);
  always_ff @(posedge clk) begin
    if (rst || prot_next) begin
      arr_ce_n <= 1'b1;
      arr_we_n <= 1'b1;
      dq_drive <= 1'b0;
    end else begin
      arr_ce_n <= host.ce_n;
      arr_we_n <= host.ce_n | host.we_n;
      dq_drive <= ~host.ce_n & ~host.oe_n & host.we_n;
    end
  end
endmodule

// File: rtl/nvs_backup_select.sv
module nvs_backup_select (
  input  logic clk,
  input  logic rst,
  input  logic seal_clear,
  input  logic run_ok,
  input  logic sw_ok,
  output logic armed,
  output logic sel_ext,
  output logic sel_bat
);
  always_ff @(posedge clk) begin
    if (seal_clear)  armed <= 1'b0;
    else if (run_ok) armed <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_ext <= 1'b0;
      sel_bat <= 1'b0;
    end else begin
      sel_ext <= sw_ok;
      sel_bat <= armed & ~sw_ok;
    end
  end
endmodule

// File: rtl/nvs_supervisor.sv
module nvs_supervisor
  import nvs_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int STABLE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic seal_clear,
  input  logic sup_run_ok,
  input  logic sup_prot_ok,
  input  logic sup_sw_ok,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  output logic arr_ce_n,
  output logic arr_we_n,
  output logic dq_drive,
  output logic pwr_sel_ext,
  output logic pwr_sel_bat,
  output logic seal_armed
);
  logic [NUM_FLAGS-1:0] raw_flags, filt_flags;
  logic run_f, prot_f, sw_f;
  logic prot_next, prot_q;
  mem_ctl_t host;

  assign raw_flags[FLAG_RUN]  = sup_run_ok;
  assign raw_flags[FLAG_PROT] = sup_prot_ok;
  assign raw_flags[FLAG_SW]   = sup_sw_ok;

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_filt
    nvs_flag_filter #(
      .SYNC_STAGES  (SYNC_STAGES),
      .STABLE_CYCLES(STABLE_CYCLES)
    ) u_filt (
      .clk (clk),
      .rst (rst),
      .raw (raw_flags[i]),
      .filt(filt_flags[i])
    );
  end

  assign run_f  = filt_flags[FLAG_RUN];
  assign prot_f = filt_flags[FLAG_PROT];
  assign sw_f   = filt_flags[FLAG_SW];
  assign host   = '{ce_n: ce_n, oe_n: oe_n, we_n: we_n};

  nvs_protect_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .run_ok   (run_f),
    .prot_ok  (prot_f),
    .prot_next(prot_next),
    .prot_q   (prot_q)
  );

  nvs_access_gate u_gate (
    .clk      (clk),
    .rst      (rst),
    .prot_next(prot_next),
    .host     (host),
    .arr_ce_n (arr_ce_n),
    .arr_we_n (arr_we_n),
    .dq_drive (dq_drive)
  );

  nvs_backup_select u_sel (
    .clk       (clk),
    .rst       (rst),
    .seal_clear(seal_clear),
    .run_ok    (run_f),
    .sw_ok     (sw_f),
    .armed     (seal_armed),
    .sel_ext   (pwr_sel_ext),
    .sel_bat   (pwr_sel_bat)
  );
endmodule

// File: rtl/nvs_supervisor_chk.sv
module nvs_supervisor_chk (
  input logic clk,
  input logic rst,
  input logic seal_clear,
  input logic prot_q,
  input logic run_f,
  input logic prot_f,
  input logic arr_ce_n,
  input logic arr_we_n,
  input logic dq_drive,
  input logic pwr_sel_ext,
  input logic pwr_sel_bat,
  input logic seal_armed
);
  assert_release_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(prot_q) |-> $past(run_f));

  assert_enter_R4: assert property (@(posedge clk) disable iff (rst)
    !prot_f |=> prot_q);

  assert_gate_off_R5: assert property (@(posedge clk) disable iff (rst)
    prot_q |-> (arr_ce_n && arr_we_n && !dq_drive));

  assert_abort_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(prot_q) |-> (arr_we_n && arr_ce_n));

  assert_read_only_R7: assert property (@(posedge clk) disable iff (rst)
    dq_drive |-> (!arr_ce_n && arr_we_n));

  assert_sel_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(pwr_sel_ext && pwr_sel_bat));

  assert_seal_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(seal_armed) && !$past(seal_clear)) |-> seal_armed);
endmodule

bind nvs_supervisor nvs_supervisor_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .seal_clear (seal_clear),
  .prot_q     (prot_q),
  .run_f      (run_f),
  .prot_f     (prot_f),
  .arr_ce_n   (arr_ce_n),
  .arr_we_n   (arr_we_n),
  .dq_drive   (dq_drive),
  .pwr_sel_ext(pwr_sel_ext),
  .pwr_sel_bat(pwr_sel_bat),
  .seal_armed (seal_armed)
);

// File: tb/tb_nvs_supervisor.sv
module tb_nvs_supervisor;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic seal_clear = 1'b1;
  logic [2:0] sup = 3'b000;  // [0] run, [1] protect, [2] switchover
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic arr_ce_n, arr_we_n, dq_drive, pwr_sel_ext, pwr_sel_bat, seal_armed;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  nvs_supervisor #(.SYNC_STAGES(2), .STABLE_CYCLES(N)) dut (
    .clk(clk), .rst(rst), .seal_clear(seal_clear),
    .sup_run_ok(sup[0]), .sup_prot_ok(sup[1]), .sup_sw_ok(sup[2]),
    .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .arr_ce_n(arr_ce_n), .arr_we_n(arr_we_n), .dq_drive(dq_drive),
    .pwr_sel_ext(pwr_sel_ext), .pwr_sel_bat(pwr_sel_bat), .seal_armed(seal_armed)
  );

  // behavioural reference model
  int s1[3], s2[3], fl[3], cnt[3];
  int m_prot = 1, m_arm = 0, m_ce = 1, m_we = 1, m_dq = 0, m_se = 0, m_sb = 0;

  initial begin
    for (int k = 0; k < 3; k++) begin
      s1[k] = 0; s2[k] = 0; fl[k] = 0; cnt[k] = 0;
    end
  end

  always @(posedge clk) begin
    int ofl[3];
    int narm;
    ofl = fl;
    narm = seal_clear ? 0 : ((m_arm != 0 || ofl[0] != 0) ? 1 : 0);
    if (rst) begin
      for (int k = 0; k < 3; k++) begin
        s1[k] = 0; s2[k] = 0; fl[k] = 0; cnt[k] = 0;
      end
      m_prot = 1; m_ce = 1; m_we = 1; m_dq = 0; m_se = 0; m_sb = 0;
    end else begin
      for (int k = 0; k < 3; k++) begin
        if (s2[k] != fl[k]) begin
          if (cnt[k] == N - 1) begin fl[k] = s2[k]; cnt[k] = 0; end
          else cnt[k]++;
        end else cnt[k] = 0;
        s2[k] = s1[k];
        s1[k] = int'(sup[k]);
      end
      if (ofl[1] == 0) m_prot = 1;
      else if (ofl[0] != 0) m_prot = 0;
      if (m_prot != 0) begin
        m_ce = 1; m_we = 1; m_dq = 0;
      end else begin
        m_ce = int'(ce_n);
        m_we = int'(ce_n | we_n);
        m_dq = (!ce_n && !oe_n && we_n) ? 1 : 0;
      end
      m_se = ofl[2];
      m_sb = (m_arm != 0 && ofl[2] == 0) ? 1 : 0;
    end
    m_arm = narm;
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, half a period after the edge
  always @(negedge clk) begin
    if (!done) begin
      chk("R5 arr_ce_n vs model", int'(arr_ce_n), m_ce);
      chk("R6 arr_we_n vs model", int'(arr_we_n), m_we);
      chk("R7 dq_drive vs model", int'(dq_drive), m_dq);
      chk("R8 pwr_sel_ext vs model", int'(pwr_sel_ext), m_se);
      chk("R8 pwr_sel_bat vs model", int'(pwr_sel_bat), m_sb);
      chk("R9 seal_armed vs model", int'(seal_armed), m_arm);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    tick(3);
    chk("R1 arr_ce_n in reset", int'(arr_ce_n), 1);
    chk("R1 arr_we_n in reset", int'(arr_we_n), 1);
    chk("R1 dq_drive in reset", int'(dq_drive), 0);
    chk("R1 pwr_sel_ext in reset", int'(pwr_sel_ext), 0);
    seal_clear = 1'b0;
    rst = 1'b0;
    tick(1);
    chk("R1 pwr_sel_bat after reset", int'(pwr_sel_bat), 0);
    chk("R9 seal_armed starts clear", int'(seal_armed), 0);

    // supply ramps: switchover first, seal still unarmed
    sup[2] = 1'b1; tick(12);
    sup[2] = 1'b0; tick(12);
    chk("R9 unarmed keeps backup off", int'(pwr_sel_bat), 0);
    sup[2] = 1'b1; tick(12);
    chk("R8 external selected", int'(pwr_sel_ext), 1);
    sup[1] = 1'b1; tick(12);
    ce_n = 1'b0; oe_n = 1'b0; tick(2);
    chk("R3 protect flag alone keeps guard", int'(dq_drive), 0);
    sup[0] = 1'b1; tick(12);
    chk("R3 released after run flag", int'(dq_drive), 1);
    chk("R9 armed at first power-up", int'(seal_armed), 1);

    // glitch shorter than the filter window
    sup[1] = 1'b0; tick(N - 1); sup[1] = 1'b1; tick(12);
    chk("R2 short glitch ignored", int'(dq_drive), 1);
    sup[0] = 1'b0; tick(N - 2); sup[0] = 1'b1; tick(12);
    chk("R2 short run glitch ignored", int'(arr_ce_n), 0);

    // read/write path
    we_n = 1'b0; tick(1);
    chk("R7 write disables drivers", int'(dq_drive), 0);
    chk("R7 write reaches array", int'(arr_we_n), 0);
    oe_n = 1'b1; ce_n = 1'b1; tick(1);
    chk("R7 idle ce follows", int'(arr_ce_n), 1);
    ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; tick(1);
    chk("R7 read drives", int'(dq_drive), 1);

    // hysteresis: run flag low only
    sup[0] = 1'b0; tick(15);
    chk("R4 between thresholds holds open", int'(dq_drive), 1);

    // write in flight, then protect flag drops
    oe_n = 1'b1; we_n = 1'b0; tick(2);
    chk("R6 write active before fault", int'(arr_we_n), 0);
    sup[1] = 1'b0; tick(15);
    chk("R6 write aborted", int'(arr_we_n), 1);
    chk("R4 protect entered", int'(arr_ce_n), 1);

    // inputs ignored while protected
    for (int i = 0; i < 8; i++) begin
      ce_n = i[0]; oe_n = i[1]; we_n = i[2]; tick(1);
      chk("R5 ce gated", int'(arr_ce_n), 1);
      chk("R5 dq off", int'(dq_drive), 0);
    end

    // power fails below switchover
    sup[2] = 1'b0; tick(12);
    chk("R8 backup selected", int'(pwr_sel_bat), 1);
    chk("R8 external released", int'(pwr_sel_ext), 0);

    // reset does not disturb the seal
    rst = 1'b1; tick(3); rst = 1'b0; tick(12);
    chk("R9 seal survives reset", int'(seal_armed), 1);
    chk("R8 backup after reset", int'(pwr_sel_bat), 1);
    sup[2] = 1'b1; tick(12);
    chk("R8 external back", int'(pwr_sel_ext), 1);
    sup[1] = 1'b1; tick(12);
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; tick(2);
    chk("R3 guard held without run flag", int'(dq_drive), 0);
    sup[0] = 1'b1; tick(12);
    chk("R3 reopened", int'(dq_drive), 1);

    // factory clear
    sup = 3'b000; tick(15);
    seal_clear = 1'b1; tick(1); seal_clear = 1'b0; tick(3);
    chk("R9 seal cleared", int'(seal_armed), 0);
    chk("R9 backup off after clear", int'(pwr_sel_bat), 0);

    tick(2);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule